// File: doc/BRIEF.md
# Command Frame Opcode Dispatcher

This block sits behind the frame-post path of a storage host adapter. The host posts the byte address of a command frame held in shared memory. The block fetches the frame header through a word-read memory port and decides the frame's outcome. It then writes a status byte back into the frame, and for some outcomes a SCSI status byte as well. It also keeps track of the controller's firmware state.

Frames that need real work are handed to an execution port and left open. These are logical reads, logical writes and pass-through commands. The execution engine later returns a final status on a done handshake. Everything else is settled inside the block: initialization, rejection, management sub-commands and error outcomes. When the controller is operational, every finished frame raises a one-cycle completion request that carries the frame address.

Only one frame is in flight at a time. While `busy` is high, posts are ignored.

Top module: `cmdframe_dispatch`

## Requirements
- R1: After reset, `fw_state` reads 0xB (ready), `busy` is low, and no memory write, completion or execution request is raised.
- R2: While `fw_state` is not 0xC (operational), a frame whose byte-0 opcode is anything other than 0x00 writes 0x08 to frame byte 2. It raises no completion and leaves `fw_state` unchanged.
- R3: While not operational, opcode 0x00 writes 0x00 to frame byte 2 and moves `fw_state` to 0xC. It raises no completion.
- R4: When operational, opcode 0x05 reads a 32-bit sub-opcode from frame offset 0x18. Sub-opcode 0x01101000 writes status 0x00. Sub-opcode 0x01050000 writes 0x00 and returns `fw_state` to 0xB. Any other sub-opcode writes 0x02. All three raise a completion.
- R5: When operational and `queue_full` is high at decision time, the frame gets SCSI status 0x08 at byte 3 and command status 0x2D at byte 2, whatever its opcode. It raises a completion.
- R6: Opcodes 0x03 and 0x04 with a byte-6 CDB length above 16 get SCSI status 0x02 at byte 3 and status 0x2D at byte 2. A length of exactly 16 is accepted.
- R7: Opcodes 0x01 to 0x04 name a target in byte 4. If that target is not below NUM_TGT, or its bit in `dev_present` is clear, the frame gets status 0x0C.
- R8: A valid frame with opcode 0x01, 0x02, or 0x03/0x04 raises a one-cycle `exec_valid` with `exec_kind` 0, 1 or 2 respectively. No status is written until `exec_done`. The status then written to byte 2 is `exec_status`, followed by a completion.
- R9: When operational, any opcode outside 0x01 to 0x05, 0x00 included, writes status 0x01 and raises a completion.
- R10: While `busy` is high, `post_valid` is ignored: the frame posted then is never read, written or executed.
- R11: When both bytes are written, the byte-3 write comes before the byte-2 write. The completion pulse comes after the byte-2 write, lasts one cycle, and carries the posted frame address on `cmpl_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Frame post strobe, taken when `busy` is low |
| post_addr | input | AW | Byte address of the posted frame (word aligned) |
| busy | output | 1 | A frame is being processed |
| queue_full | input | 1 | Reply queue has no room |
| dev_present | input | NUM_TGT | One bit per target: a device is attached |
| mem_rd_req | output | 1 | One-cycle word read request |
| mem_rd_addr | output | AW | Byte address of the word to read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read word, byte 0 in bits 7:0 |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_addr | output | AW | Byte address written |
| mem_wr_data | output | 8 | Byte value written |
| exec_valid | output | 1 | One-cycle hand-off to the execution engine |
| exec_kind | output | 2 | 0 read, 1 write, 2 pass-through |
| exec_addr | output | AW | Frame address handed off |
| exec_done | input | 1 | Execution finished |
| exec_status | input | 8 | Final command status from execution |
| cmpl_valid | output | 1 | One-cycle completion request |
| cmpl_addr | output | AW | Address of the completed frame |
| fw_state | output | 4 | Firmware state: 0xB ready, 0xC operational |

## Verification
The hardest case to reach is a second post that arrives while a frame sits open on the execution port. That situation needs the controller operational, a present target and an engine that has not answered yet. The stimulus first initializes the controller and posts a logical read to an attached target. It holds back `exec_done` and posts a second frame in the meantime. After the first frame finishes, it confirms that the second address was never read back, written or handed off. Each precedence level is also reached on purpose: state gate, then queue-full, then CDB length, then target presence. Every such frame is built so that it would also trip the next rule down.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  // firmware states
  localparam logic [3:0] FW_READY = 4'hB;
  localparam logic [3:0] FW_OPER  = 4'hC;

  // frame opcodes
  localparam logic [7:0] OP_INIT   = 8'h00;
  localparam logic [7:0] OP_LREAD  = 8'h01;
  localparam logic [7:0] OP_LWRITE = 8'h02;
  localparam logic [7:0] OP_LPASS  = 8'h03;
  localparam logic [7:0] OP_PPASS  = 8'h04;
  localparam logic [7:0] OP_MGMT   = 8'h05;

  // management sub-opcodes
  localparam logic [31:0] SUB_FLUSH    = 32'h0110_1000;
  localparam logic [31:0] SUB_SHUTDOWN = 32'h0105_0000;

  // command status codes
  localparam logic [7:0] ST_OK       = 8'h00;
  localparam logic [7:0] ST_BAD_OP   = 8'h01;
  localparam logic [7:0] ST_BAD_SUB  = 8'h02;
  localparam logic [7:0] ST_NOT_INIT = 8'h08;
  localparam logic [7:0] ST_NO_DEV   = 8'h0C;
  localparam logic [7:0] ST_SCSI_ERR = 8'h2D;

  // SCSI status codes
  localparam logic [7:0] SS_CHECK = 8'h02;
  localparam logic [7:0] SS_BUSY  = 8'h08;

  // byte offsets inside a frame
  localparam int OFF_CMD_ST  = 2;
  localparam int OFF_SCSI_ST = 3;
  localparam int OFF_HDR1    = 4;
  localparam int OFF_SUB     = 24;

  typedef enum logic [1:0] {
    XK_READ  = 2'd0,
    XK_WRITE = 2'd1,
    XK_PASS  = 2'd2
  } xkind_e;

  typedef struct packed {
    logic       is_exec;
    xkind_e     kind;
    logic       wr_scsi;
    logic [7:0] scsi_st;
    logic [7:0] cmd_st;
    logic       cmpl;
    logic       go_oper;
    logic       go_ready;
  } outcome_t;

endpackage

// File: rtl/cfd_fetch.sv
module cfd_fetch #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic [DW-1:0] word
);

  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
      pending <= 1'b0;
      done    <= 1'b0;
      word    <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rd_req  <= 1'b1;
        rd_addr <= addr;
        pending <= 1'b1;
      end else begin
        rd_req <= 1'b0;
      end
      if (pending && rd_valid) begin
        pending <= 1'b0;
        word    <= rd_data;
        done    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfd_decode.sv
module cfd_decode
  import cfd_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int MAX_CDB = 16
) (
  input  logic [3:0]         fw_state,
  input  logic [7:0]         opcode,
  input  logic [7:0]         target,
  input  logic [7:0]         cdb_len,
  input  logic [31:0]        sub_op,
  input  logic               queue_full,
  input  logic [NUM_TGT-1:0] dev_present,
  output outcome_t           oc
);

  localparam int TW = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

  logic present;
  logic cdb_bad;

  always_comb begin
    present = 1'b0;
    if (32'(target) < NUM_TGT) present = dev_present[target[TW-1:0]];
    cdb_bad = 32'(cdb_len) > MAX_CDB;
  end

  always_comb begin
    oc         = '0;
    oc.kind    = XK_READ;
    oc.scsi_st = 8'h00;
    oc.cmd_st  = ST_OK;
    if (fw_state != FW_OPER) begin
      if (opcode == OP_INIT) begin
        oc.go_oper = 1'b1;
      end else begin
        oc.cmd_st = ST_NOT_INIT;
      end
    end else begin
      oc.cmpl = 1'b1;
      if (queue_full) begin
        oc.wr_scsi = 1'b1;
        oc.scsi_st = SS_BUSY;
        oc.cmd_st  = ST_SCSI_ERR;
      end else begin
        unique case (opcode)
          OP_MGMT: begin
            if (sub_op == SUB_FLUSH) begin
              oc.cmd_st = ST_OK;
            end else if (sub_op == SUB_SHUTDOWN) begin
              oc.cmd_st   = ST_OK;
              oc.go_ready = 1'b1;
            end else begin
              oc.cmd_st = ST_BAD_SUB;
            end
          end
          OP_LPASS, OP_PPASS: begin
            if (cdb_bad) begin
              oc.wr_scsi = 1'b1;
              oc.scsi_st = SS_CHECK;
              oc.cmd_st  = ST_SCSI_ERR;
            end else if (!present) begin
              oc.cmd_st = ST_NO_DEV;
            end else begin
              oc.is_exec = 1'b1;
              oc.kind    = XK_PASS;
            end
          end
          OP_LREAD, OP_LWRITE: begin
            if (!present) begin
              oc.cmd_st = ST_NO_DEV;
            end else begin
              oc.is_exec = 1'b1;
              oc.kind    = (opcode == OP_LWRITE) ? XK_WRITE : XK_READ;
            end
          end
          default: oc.cmd_st = ST_BAD_OP;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfd_fwstate.sv
module cfd_fwstate
  import cfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       set_oper,
  input  logic       set_ready,
  output logic [3:0] state
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FW_READY;
    end else if (set_oper) begin
      state <= FW_OPER;
    end else if (set_ready) begin
      state <= FW_READY;
    end
  end

endmodule

// File: rtl/cmdframe_dispatch.sv
module cmdframe_dispatch
  import cfd_pkg::*;
#(
  parameter int AW      = 32,
  parameter int NUM_TGT = 8,
  parameter int MAX_CDB = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_valid,
  input  logic [AW-1:0]      post_addr,
  output logic               busy,
  input  logic               queue_full,
  input  logic [NUM_TGT-1:0] dev_present,
  output logic               mem_rd_req,
  output logic [AW-1:0]      mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [31:0]        mem_rd_data,
  output logic               mem_wr_en,
  output logic [AW-1:0]      mem_wr_addr,
  output logic [7:0]         mem_wr_data,
  output logic               exec_valid,
  output logic [1:0]         exec_kind,
  output logic [AW-1:0]      exec_addr,
  input  logic               exec_done,
  input  logic [7:0]         exec_status,
  output logic               cmpl_valid,
  output logic [AW-1:0]      cmpl_addr,
  output logic [3:0]         fw_state
);

  typedef enum logic [3:0] {
    S_IDLE, S_RQ0, S_W0, S_RQ1, S_W1, S_RQS, S_WS,
    S_DEC, S_WCMD, S_EXW, S_FIN
  } st_e;

  st_e           st;
  logic [AW-1:0] base;
  logic [7:0]    op_q, tgt_q, cdb_q;
  logic [31:0]   sub_q;
  outcome_t      oc, oc_q;
  logic [7:0]    final_st;

  logic          f_go, f_done;
  logic [AW-1:0] f_addr;
  logic [31:0]   f_word;

  always_comb begin
    f_go   = (st == S_RQ0) || (st == S_RQ1) || (st == S_RQS);
    f_addr = base;
    if (st == S_RQ1) f_addr = base + AW'(OFF_HDR1);
    if (st == S_RQS) f_addr = base + AW'(OFF_SUB);
  end

  cfd_fetch #(.AW(AW), .DW(32)) u_fetch (
    .clk(clk), .rst(rst), .go(f_go), .addr(f_addr),
    .rd_req(mem_rd_req), .rd_addr(mem_rd_addr),
    .rd_valid(mem_rd_valid), .rd_data(mem_rd_data),
    .done(f_done), .word(f_word)
  );

  cfd_decode #(.NUM_TGT(NUM_TGT), .MAX_CDB(MAX_CDB)) u_dec (
    .fw_state(fw_state), .opcode(op_q), .target(tgt_q), .cdb_len(cdb_q),
    .sub_op(sub_q), .queue_full(queue_full), .dev_present(dev_present),
    .oc(oc)
  );

  cfd_fwstate u_fw (
    .clk(clk), .rst(rst),
    .set_oper((st == S_DEC) && oc.go_oper),
    .set_ready((st == S_DEC) && oc.go_ready),
    .state(fw_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      base        <= '0;
      busy        <= 1'b0;
      op_q        <= '0;
      tgt_q       <= '0;
      cdb_q       <= '0;
      sub_q       <= '0;
      oc_q        <= '0;
      final_st    <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      exec_valid  <= 1'b0;
      exec_kind   <= '0;
      exec_addr   <= '0;
      cmpl_valid  <= 1'b0;
      cmpl_addr   <= '0;
    end else begin
      mem_wr_en  <= 1'b0;
      exec_valid <= 1'b0;
      cmpl_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (post_valid) begin
          base  <= post_addr;
          busy  <= 1'b1;
          tgt_q <= '0;
          cdb_q <= '0;
          sub_q <= '0;
          st    <= S_RQ0;
        end
        S_RQ0: st <= S_W0;
        S_W0: if (f_done) begin
          op_q <= f_word[7:0];
          st   <= (fw_state == FW_OPER) ? S_RQ1 : S_DEC;
        end
        S_RQ1: st <= S_W1;
        S_W1: if (f_done) begin
          tgt_q <= f_word[7:0];
          cdb_q <= f_word[23:16];
          st    <= (op_q == OP_MGMT) ? S_RQS : S_DEC;
        end
        S_RQS: st <= S_WS;
        S_WS: if (f_done) begin
          sub_q <= f_word;
          st    <= S_DEC;
        end
        S_DEC: begin
          oc_q     <= oc;
          final_st <= oc.cmd_st;
          if (oc.is_exec) begin
            exec_valid <= 1'b1;
            exec_kind  <= oc.kind;
            exec_addr  <= base;
            st         <= S_EXW;
          end else if (oc.wr_scsi) begin
            mem_wr_en   <= 1'b1;
            mem_wr_addr <= base + AW'(OFF_SCSI_ST);
            mem_wr_data <= oc.scsi_st;
            st          <= S_WCMD;
          end else begin
            mem_wr_en   <= 1'b1;
            mem_wr_addr <= base + AW'(OFF_CMD_ST);
            mem_wr_data <= oc.cmd_st;
            st          <= S_FIN;
          end
        end
        S_EXW: if (exec_done) begin
          final_st <= exec_status;
          st       <= S_WCMD;
        end
        S_WCMD: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= base + AW'(OFF_CMD_ST);
          mem_wr_data <= final_st;
          st          <= S_FIN;
        end
        S_FIN: begin
          busy       <= 1'b0;
          cmpl_valid <= oc_q.cmpl;
          cmpl_addr  <= base;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfd_checker.sv
module cfd_checker (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       mem_rd_req,
  input logic       mem_wr_en,
  input logic       exec_valid,
  input logic       cmpl_valid,
  input logic [3:0] fw_state
);

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
    (fw_state == 4'hB) || (fw_state == 4'hC));

  assert_state_moves_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(fw_state) |-> $past(busy));

  assert_exec_alone_R8: assert property (@(posedge clk) disable iff (rst)
    exec_valid |-> (busy && !mem_wr_en));

  assert_read_in_frame_R10: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> busy);

  assert_write_in_frame_R11: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> busy);

  assert_cmpl_single_R11: assert property (@(posedge clk) disable iff (rst)
    cmpl_valid |=> !cmpl_valid);

endmodule

bind cmdframe_dispatch cfd_checker u_cfd_checker (
  .clk(clk), .rst(rst), .busy(busy), .mem_rd_req(mem_rd_req),
  .mem_wr_en(mem_wr_en), .exec_valid(exec_valid),
  .cmpl_valid(cmpl_valid), .fw_state(fw_state)
);

// File: tb/cmdframe_dispatch_tb_top.sv
module cmdframe_dispatch_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        post_valid = 1'b0;
  logic [31:0] post_addr = '0;
  logic        busy;
  logic        queue_full = 1'b0;
  logic [7:0]  dev_present = 8'b0000_0011;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        mem_wr_en;
  logic [31:0] mem_wr_addr;
  logic [7:0]  mem_wr_data;
  logic        exec_valid;
  logic [1:0]  exec_kind;
  logic [31:0] exec_addr;
  logic        exec_done = 1'b0;
  logic [7:0]  exec_status = '0;
  logic        cmpl_valid;
  logic [31:0] cmpl_addr;
  logic [3:0]  fw_state;

  always #4 clk = ~clk;

  cmdframe_dispatch dut_i (.*);

  logic [31:0] mem [0:255];
  int tests = 0, fails = 0;
  bit finished = 0;

  // logs filled by the monitor only
  int          wcnt = 0, ccnt = 0, xcnt = 0, rcnt = 0;
  logic [31:0] wl_addr [0:255];
  logic [7:0]  wl_data [0:255];
  logic [31:0] cl_addr;
  int          cl_at;
  logic [1:0]  xl_kind;
  logic [31:0] xl_addr;
  logic [31:0] rl_addr [0:255];

  always @(negedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_req) begin
      mem_rd_valid <= 1'b1;
      mem_rd_data  <= mem[mem_rd_addr[9:2]];
      rl_addr[rcnt % 256] = mem_rd_addr;
      rcnt = rcnt + 1;
    end
    if (mem_wr_en) begin
      wl_addr[wcnt % 256] = mem_wr_addr;
      wl_data[wcnt % 256] = mem_wr_data;
      wcnt = wcnt + 1;
    end
    if (cmpl_valid) begin
      cl_addr = cmpl_addr;
      cl_at   = wcnt;
      ccnt    = ccnt + 1;
    end
    if (exec_valid) begin
      xl_kind = exec_kind;
      xl_addr = exec_addr;
      xcnt    = xcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [31:0] f, input logic [7:0] op, input logic [7:0] tgt,
                       input logic [7:0] cdb, input logic [31:0] sub);
    mem[f[9:2]]     = {8'h00, 8'hFF, 8'h00, op};
    mem[f[9:2] + 1] = {8'h01, cdb, 8'h00, tgt};
    mem[f[9:2] + 6] = sub;
  endtask

  task automatic post(input logic [31:0] f);
    @(negedge clk);
    post_valid = 1'b1;
    post_addr  = f;
    @(negedge clk);
    post_valid = 1'b0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  // posts a frame that settles inside the block and checks writes/completion
  task automatic expect_frame(input logic [31:0] f, input string req, input bit scsi_w,
                              input logic [7:0] scsi, input logic [7:0] st, input bit cm);
    int w0 = wcnt, c0 = ccnt, x0 = xcnt;
    int n;
    post(f);
    wait_idle();
    n = wcnt - w0;
    chk(n == (scsi_w ? 2 : 1), req, n, scsi_w ? 2 : 1);
    if (scsi_w && n == 2) begin
      chk(wl_addr[w0 % 256] == f + 3 && wl_data[w0 % 256] == scsi, req,
          {wl_addr[w0 % 256], wl_data[w0 % 256]}, {f + 3, scsi});
    end
    if (n >= 1) begin
      chk(wl_addr[(wcnt - 1) % 256] == f + 2 && wl_data[(wcnt - 1) % 256] == st, req,
          {wl_addr[(wcnt - 1) % 256], wl_data[(wcnt - 1) % 256]}, {f + 2, st});
    end
    chk((ccnt - c0) == (cm ? 1 : 0), req, ccnt - c0, cm ? 1 : 0);
    if (cm && ccnt > c0) chk(cl_addr == f && cl_at == wcnt, "R11", cl_addr, f);
    chk(xcnt == x0, req, xcnt - x0, 0);
  endtask

  task automatic t_reset;
    chk(fw_state == 4'hB, "R1", fw_state, 4'hB);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(wcnt == 0 && ccnt == 0 && xcnt == 0, "R1", wcnt + ccnt + xcnt, 0);
  endtask

  task automatic t_preinit;
    build(32'h040, 8'h01, 8'h00, 8'h06, 32'h0);
    expect_frame(32'h040, "R2", 0, 8'h00, 8'h08, 0);
    build(32'h060, 8'h05, 8'h00, 8'h06, 32'h0110_1000);
    expect_frame(32'h060, "R2", 0, 8'h00, 8'h08, 0);
    chk(fw_state == 4'hB, "R2", fw_state, 4'hB);
  endtask

  task automatic t_init;
    build(32'h080, 8'h00, 8'h00, 8'h00, 32'h0);
    expect_frame(32'h080, "R3", 0, 8'h00, 8'h00, 0);
    chk(fw_state == 4'hC, "R3", fw_state, 4'hC);
  endtask

  task automatic t_mgmt;
    build(32'h0A0, 8'h05, 8'h00, 8'h00, 32'h0110_1000);
    expect_frame(32'h0A0, "R4", 0, 8'h00, 8'h00, 1);
    build(32'h0C0, 8'h05, 8'h00, 8'h00, 32'h0101_0000);
    expect_frame(32'h0C0, "R4", 0, 8'h00, 8'h02, 1);
    chk(fw_state == 4'hC, "R4", fw_state, 4'hC);
  endtask

  task automatic t_unknown;
    build(32'h0E0, 8'h09, 8'h00, 8'h00, 32'h0);
    expect_frame(32'h0E0, "R9", 0, 8'h00, 8'h01, 1);
    build(32'h100, 8'h00, 8'h00, 8'h00, 32'h0);
    expect_frame(32'h100, "R9", 0, 8'h00, 8'h01, 1);
    chk(fw_state == 4'hC, "R9", fw_state, 4'hC);
  endtask

  task automatic t_qfull;
    queue_full = 1'b1;
    build(32'h120, 8'h04, 8'h05, 8'd20, 32'h0);
    expect_frame(32'h120, "R5", 1, 8'h08, 8'h2D, 1);
    build(32'h140, 8'h05, 8'h00, 8'h00, 32'h0105_0000);
    expect_frame(32'h140, "R5", 1, 8'h08, 8'h2D, 1);
    chk(fw_state == 4'hC, "R5", fw_state, 4'hC);
    queue_full = 1'b0;
  endtask

  task automatic t_cdb;
    build(32'h160, 8'h03, 8'h05, 8'd17, 32'h0);
    expect_frame(32'h160, "R6", 1, 8'h02, 8'h2D, 1);
  endtask

  task automatic t_absent;
    build(32'h180, 8'h01, 8'h02, 8'h00, 32'h0);
    expect_frame(32'h180, "R7", 0, 8'h00, 8'h0C, 1);
    build(32'h1A0, 8'h04, 8'h09, 8'd16, 32'h0);
    expect_frame(32'h1A0, "R7", 0, 8'h00, 8'h0C, 1);
  endtask

  task automatic run_exec(input logic [31:0] f, input logic [7:0] op, input logic [7:0] cdb,
                          input logic [1:0] kind, input logic [7:0] st,
                          input bit extra_post, input logic [31:0] f2);
    int w0 = wcnt, c0 = ccnt, x0 = xcnt, r0 = rcnt;
    build(f, op, 8'h01, cdb, 32'h0);
    post(f);
    for (int i = 0; i < 100; i++) begin
      if (xcnt != x0) break;
      @(negedge clk);
    end
    chk(xcnt - x0 == 1, "R8", xcnt - x0, 1);
    chk(xl_kind == kind && xl_addr == f, "R8", {xl_kind, xl_addr}, {kind, f});
    if (extra_post) post(f2);
    repeat (6) @(negedge clk);
    chk(wcnt == w0 && busy, "R8", wcnt - w0, 0);
    exec_done   = 1'b1;
    exec_status = st;
    @(negedge clk);
    exec_done = 1'b0;
    wait_idle();
    chk(wcnt - w0 == 1 && wl_addr[w0 % 256] == f + 2 && wl_data[w0 % 256] == st, "R8",
        {wl_addr[w0 % 256], wl_data[w0 % 256]}, {f + 2, st});
    chk(ccnt - c0 == 1 && cl_addr == f, "R8", cl_addr, f);
    if (extra_post) begin
      repeat (10) @(negedge clk);
      chk(xcnt - x0 == 1 && wcnt - w0 == 1, "R10", wcnt - w0, 1);
      for (int i = r0; i < rcnt; i++)
        chk(rl_addr[i % 256][9:5] != f2[9:5], "R10", rl_addr[i % 256], f);
    end
  endtask

  task automatic t_shutdown;
    build(32'h260, 8'h05, 8'h00, 8'h00, 32'h0105_0000);
    expect_frame(32'h260, "R4", 0, 8'h00, 8'h00, 1);
    chk(fw_state == 4'hB, "R4", fw_state, 4'hB);
    build(32'h280, 8'h02, 8'h00, 8'h00, 32'h0);
    expect_frame(32'h280, "R2", 0, 8'h00, 8'h08, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_preinit();
    t_init();
    t_mgmt();
    t_unknown();
    t_qfull();
    t_cdb();
    t_absent();
    run_exec(32'h1C0, 8'h01, 8'h00, 2'd0, 8'h00, 0, 32'h0);
    run_exec(32'h1E0, 8'h02, 8'h00, 2'd1, 8'h2E, 0, 32'h0);
    run_exec(32'h200, 8'h03, 8'd16, 2'd2, 8'h2D, 0, 32'h0);
    build(32'h240, 8'h09, 8'h00, 8'h00, 32'h0);
    run_exec(32'h220, 8'h01, 8'h00, 2'd0, 8'h00, 1, 32'h240);
    t_shutdown();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule